// File: doc/BRIEF.md
# Revocation Bitmap Load Filter

This block keeps a shadow bitmap with one bit for each fixed-size granule of a memory window. A set bit marks the granule as revoked. A range engine takes the lower and upper bounds of a capability and sets the bits of every granule the range touches, one granule per clock. A second request port uses the same engine to clear bits again, so that the memory can be handed out once more. The engine reports `range_busy` while it runs and pulses `range_done` for one cycle when it finishes.

Capability loads pass through a one-cycle filter. The filter uses the base address of each loaded capability to look up the granule that contains it. If that granule is marked, the filter drops the tag. The address and payload pass through unchanged. A lookup in the same cycle as a write to its granule sees the value being written. Revocation therefore takes effect on the first load after marking reaches that granule, and memory never has to be swept.

After reset, the engine walks the whole bitmap and zeroes it. It accepts no request until that walk is over.

Top module: `revmap_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `range_busy` is 1. The engine zeroes all MAP_BITS granules, one per cycle, so `range_busy` falls MAP_BITS+1 cycles after reset is released. No `range_done` pulse is given for this walk. Afterwards, no granule is marked.
- R2: A paint request sets every granule index from floor((base-WIN_BASE)/2^GRAN_LG) up to ceil((top-WIN_BASE)/2^GRAN_LG), excluding the upper index. `top` is exclusive, and one granule is written per cycle.
- R3: Take N as the number of granules in the clipped range. `range_busy` is 1 in the cycle after the request is sampled. `range_done` is high for exactly one cycle, N+1 cycles after the sampling edge, and `range_busy` is 0 from that cycle on.
- R4: A clear request zeroes the granules of its range, using the same rounding and timing as a paint request.
- R5: A request that arrives while `range_busy` is 1 is ignored. When a paint request and a clear request arrive together while the engine is idle, the paint request is taken and the clear request is dropped.
- R6: Each load appears at the outputs exactly one cycle later. `out_valid` equals the `ld_valid` of that earlier cycle, and `out_addr` and `out_payload` are copies of the inputs.
- R7: `out_tag` is 0 when the granule that holds `ld_addr` lies in the window and is marked. Otherwise `out_tag` equals `ld_tag`. A tag that is 0 on input is never set to 1.
- R8: An address outside [WIN_BASE, WIN_BASE + MAP_BITS*2^GRAN_LG) is treated as not revoked. Any part of a paint or clear range that lies outside the window is dropped.
- R9: A load that is sampled at the same edge as a write to its granule sees the value being written. A paint write drops the tag, and a clear write keeps it.
- R10: A range whose clipped upper granule index is not above its lower one writes nothing. `range_done` then arrives one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paint_req | input | 1 | Start marking a range (sampled when idle) |
| paint_base | input | ADDR_W | Lower bound of the range to mark |
| paint_top | input | ADDR_W | Exclusive upper bound of the range to mark |
| clear_req | input | 1 | Start unmarking a range (sampled when idle) |
| clear_base | input | ADDR_W | Lower bound of the range to unmark |
| clear_top | input | ADDR_W | Exclusive upper bound of the range to unmark |
| range_busy | output | 1 | Range engine is running |
| range_done | output | 1 | One-cycle pulse when a requested range completes |
| ld_valid | input | 1 | Loaded capability present |
| ld_addr | input | ADDR_W | Base address of the loaded capability |
| ld_tag | input | 1 | Tag of the loaded capability |
| ld_payload | input | PAYLOAD_W | Remaining capability bits |
| out_valid | output | 1 | Filtered capability present |
| out_addr | output | ADDR_W | Base address, delayed one cycle |
| out_tag | output | 1 | Tag after revocation masking |
| out_payload | output | PAYLOAD_W | Payload, delayed one cycle |

## Verification
The bench uses a 64-granule window. After every range operation, it probes every granule plus addresses just below and just above the window. This check tells apart off-by-one rounding at either end, and it shows whether bits outside the range were disturbed. Several range shapes are tried:
- aligned ranges;
- misaligned ranges;
- ranges that straddle either edge of the window;
- empty ranges;
- ranges that hit a request while the engine is busy;
- simultaneous paint and clear requests.

Each shape exposes a different fault in clipping, in priority or in the done timing. A separate sequence issues loads in step with the engine's writes, in both paint and clear mode, to show that the lookup forwards each write. Probing with both tag values separates real masking from a tag forced to a constant.

// File: rtl/revmap_pkg.sv
package revmap_pkg;
  typedef enum logic {
    OP_UNMARK = 1'b0,
    OP_MARK   = 1'b1
  } range_op_e;
endpackage

// File: rtl/revmap_bit_ram.sv
module revmap_bit_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  // Simple dual-port, read-before-write; contents have no reset.
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/revmap_range_walker.sv
module revmap_range_walker
  import revmap_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                GRAN_LG  = 3,
  parameter int                MAP_BITS = 512,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  localparam int               IDX_W    = $clog2(MAP_BITS) + 1,
  localparam int               RIDX     = $clog2(MAP_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              paint_req,
  input  logic [ADDR_W-1:0] paint_base,
  input  logic [ADDR_W-1:0] paint_top,
  input  logic              clear_req,
  input  logic [ADDR_W-1:0] clear_base,
  input  logic [ADDR_W-1:0] clear_top,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [RIDX-1:0]   wr_idx,
  output logic              wr_val
);
  localparam logic [ADDR_W:0]  WIN_SPAN = (ADDR_W+1)'(MAP_BITS) << GRAN_LG;
  localparam logic [ADDR_W:0]  GMASK    = (ADDR_W+1)'((1 << GRAN_LG) - 1);
  localparam logic [IDX_W-1:0] MAP_END  = IDX_W'(MAP_BITS);

  function automatic logic [ADDR_W:0] win_off(input logic [ADDR_W-1:0] a);
    return {1'b0, a} - {1'b0, WIN_BASE};
  endfunction

  // First granule touched, clipped to the window.
  function automatic logic [IDX_W-1:0] lo_gran(input logic [ADDR_W-1:0] a);
    logic [ADDR_W:0] off;
    off = win_off(a);
    if (off[ADDR_W])       return '0;
    else if (off >= WIN_SPAN) return MAP_END;
    else                   return IDX_W'(off >> GRAN_LG);
  endfunction

  // One past the last granule touched (exclusive top rounded up), clipped.
  function automatic logic [IDX_W-1:0] hi_gran(input logic [ADDR_W-1:0] a);
    logic [ADDR_W:0] off;
    off = win_off(a);
    if (off[ADDR_W] || off == '0) return '0;
    else if (off >= WIN_SPAN)     return MAP_END;
    else                          return IDX_W'((off + GMASK) >> GRAN_LG);
  endfunction

  logic             busy_q, init_q, done_q;
  range_op_e        op_q;
  logic [IDX_W-1:0] cur_q, hi_q;
  logic             step;

  assign step   = busy_q && (cur_q < hi_q);
  assign busy   = busy_q;
  assign done   = done_q;
  assign wr_en  = step;
  assign wr_idx = cur_q[RIDX-1:0];
  assign wr_val = (op_q == OP_MARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b1;
      init_q <= 1'b1;
      done_q <= 1'b0;
      op_q   <= OP_UNMARK;
      cur_q  <= '0;
      hi_q   <= MAP_END;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (paint_req) begin
          busy_q <= 1'b1;
          op_q   <= OP_MARK;
          cur_q  <= lo_gran(paint_base);
          hi_q   <= hi_gran(paint_top);
        end else if (clear_req) begin
          busy_q <= 1'b1;
          op_q   <= OP_UNMARK;
          cur_q  <= lo_gran(clear_base);
          hi_q   <= hi_gran(clear_top);
        end
      end else if (step) begin
        cur_q <= cur_q + 1'b1;
      end else begin
        busy_q <= 1'b0;
        done_q <= !init_q;
        init_q <= 1'b0;
      end
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_walk_order_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!wr_en || wr_idx == $past(wr_idx) + 1'b1));
  assert_busy_ignores_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || ($stable(hi_q) && $stable(op_q))));
  assert_paint_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && paint_req) |=> (busy && wr_val));
endmodule

// File: rtl/revmap_tag_stage.sv
module revmap_tag_stage #(
  parameter int                ADDR_W    = 32,
  parameter int                PAYLOAD_W = 64,
  parameter int                GRAN_LG   = 3,
  parameter int                MAP_BITS  = 512,
  parameter logic [ADDR_W-1:0] WIN_BASE  = '0,
  localparam int               RIDX      = $clog2(MAP_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_valid,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  logic                 ld_tag,
  input  logic [PAYLOAD_W-1:0] ld_payload,
  output logic [RIDX-1:0]      rd_idx,
  input  logic                 rd_bit,
  input  logic                 wr_en,
  input  logic [RIDX-1:0]      wr_idx,
  input  logic                 wr_val,
  output logic                 out_valid,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_tag,
  output logic [PAYLOAD_W-1:0] out_payload
);
  localparam logic [ADDR_W:0] WIN_SPAN = (ADDR_W+1)'(MAP_BITS) << GRAN_LG;

  logic [ADDR_W:0]    off;
  logic               in_win, fwd_hit;
  logic               vld_q, tag_q, win_q, fwd_q, fwdv_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [PAYLOAD_W-1:0] pay_q;
  logic               revoked;

  assign off     = {1'b0, ld_addr} - {1'b0, WIN_BASE};
  assign in_win  = !off[ADDR_W] && (off < WIN_SPAN);
  assign rd_idx  = off[GRAN_LG +: RIDX];
  assign fwd_hit = wr_en && (wr_idx == rd_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      tag_q  <= 1'b0;
      win_q  <= 1'b0;
      fwd_q  <= 1'b0;
      fwdv_q <= 1'b0;
    end else begin
      vld_q  <= ld_valid;
      tag_q  <= ld_tag;
      win_q  <= in_win;
      fwd_q  <= fwd_hit;
      fwdv_q <= wr_val;
    end
    addr_q <= ld_addr;
    pay_q  <= ld_payload;
  end

  assign revoked     = win_q && (fwd_q ? fwdv_q : rd_bit);
  assign out_valid   = vld_q;
  assign out_addr    = addr_q;
  assign out_payload = pay_q;
  assign out_tag     = tag_q && !revoked;

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (out_valid && out_addr == $past(ld_addr)
                  && out_payload == $past(ld_payload)));
  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> !out_valid);
  assert_no_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !ld_tag) |=> !out_tag);
  assert_outside_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !in_win) |=> (out_tag == $past(ld_tag)));
  assert_fwd_mark_R9: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && in_win && fwd_hit && wr_val) |=> !out_tag);
  assert_fwd_unmark_R9: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && in_win && fwd_hit && !wr_val) |=> (out_tag == $past(ld_tag)));
endmodule

// File: rtl/revmap_filter.sv
module revmap_filter #(
  parameter int                ADDR_W    = 32,
  parameter int                PAYLOAD_W = 64,
  parameter int                GRAN_LG   = 3,
  parameter int                MAP_BITS  = 512,
  parameter logic [ADDR_W-1:0] WIN_BASE  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 paint_req,
  input  logic [ADDR_W-1:0]    paint_base,
  input  logic [ADDR_W-1:0]    paint_top,
  input  logic                 clear_req,
  input  logic [ADDR_W-1:0]    clear_base,
  input  logic [ADDR_W-1:0]    clear_top,
  output logic                 range_busy,
  output logic                 range_done,
  input  logic                 ld_valid,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  logic                 ld_tag,
  input  logic [PAYLOAD_W-1:0] ld_payload,
  output logic                 out_valid,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_tag,
  output logic [PAYLOAD_W-1:0] out_payload
);
  localparam int RIDX = $clog2(MAP_BITS);

  logic            wr_en, wr_val, rd_bit;
  logic [RIDX-1:0] wr_idx, rd_idx;

  revmap_range_walker #(
    .ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .MAP_BITS(MAP_BITS), .WIN_BASE(WIN_BASE)
  ) u_walker (
    .clk(clk), .rst(rst),
    .paint_req(paint_req), .paint_base(paint_base), .paint_top(paint_top),
    .clear_req(clear_req), .clear_base(clear_base), .clear_top(clear_top),
    .busy(range_busy), .done(range_done),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val)
  );

  revmap_bit_ram #(.DEPTH(MAP_BITS), .AW(RIDX)) u_map (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_val),
    .raddr(rd_idx), .rdata(rd_bit)
  );

  revmap_tag_stage #(
    .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W), .GRAN_LG(GRAN_LG),
    .MAP_BITS(MAP_BITS), .WIN_BASE(WIN_BASE)
  ) u_stage (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag(ld_tag), .ld_payload(ld_payload),
    .rd_idx(rd_idx), .rd_bit(rd_bit),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .out_valid(out_valid), .out_addr(out_addr), .out_tag(out_tag),
    .out_payload(out_payload)
  );
endmodule

// File: tb/revmap_filter_test.sv
`timescale 1ns/1ps
module revmap_filter_test;
  localparam int AW = 16;
  localparam int PW = 16;
  localparam int NG = 64;
  localparam int GB = 8;
  localparam int WB = 16'h0400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic paint_req = 0, clear_req = 0, ld_valid = 0, ld_tag = 0;
  logic [AW-1:0] paint_base = 0, paint_top = 0, clear_base = 0, clear_top = 0, ld_addr = 0;
  logic [PW-1:0] ld_payload = 0;
  logic range_busy, range_done, out_valid, out_tag;
  logic [AW-1:0] out_addr;
  logic [PW-1:0] out_payload;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit model [NG];

  always #2.5 clk = ~clk;

  revmap_filter #(.ADDR_W(AW), .PAYLOAD_W(PW), .GRAN_LG(3), .MAP_BITS(NG),
                  .WIN_BASE(16'h0400)) uut (
    .clk(clk), .rst(rst),
    .paint_req(paint_req), .paint_base(paint_base), .paint_top(paint_top),
    .clear_req(clear_req), .clear_base(clear_base), .clear_top(clear_top),
    .range_busy(range_busy), .range_done(range_done),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag(ld_tag), .ld_payload(ld_payload),
    .out_valid(out_valid), .out_addr(out_addr), .out_tag(out_tag),
    .out_payload(out_payload)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lo_of(input int a);
    int o = a - WB;
    if (o < 0) return 0;
    if (o >= NG*GB) return NG;
    return o / GB;
  endfunction

  function automatic int hi_of(input int a);
    int o = a - WB;
    if (o <= 0) return 0;
    if (o >= NG*GB) return NG;
    return (o + GB - 1) / GB;
  endfunction

  // One load; starts and ends at a negedge.
  task automatic do_load(input int a, input bit tg, input bit exp_tag, input string req);
    logic [PW-1:0] p = PW'(a * 7 + 16'h3c5);
    ld_valid = 1; ld_addr = AW'(a); ld_tag = tg; ld_payload = p;
    @(posedge clk); @(negedge clk);
    ld_valid = 0;
    chk(out_valid == 1'b1, "R6 valid", out_valid, 1);
    chk(out_addr == AW'(a) && out_payload == p, "R6 passthrough", out_payload, p);
    chk(out_tag == exp_tag, req, out_tag, exp_tag);
  endtask

  task automatic sweep(input bit tg);
    for (int g = 0; g < NG; g++)
      do_load(WB + g*GB + (g % GB), tg, tg && !model[g], "R7 granule tag");
    do_load(WB - 1, tg, tg, "R8 below window");
    do_load(WB + NG*GB, tg, tg, "R8 above window");
    do_load(16'hFFF8, tg, tg, "R8 far address");
  endtask

  // Issue paint and/or clear together; paint has priority (R5).
  task automatic range_op(input bit pe, input int pb, input int pt,
                          input bit ce, input int cb, input int ct);
    int lo, hi, n, cnt;
    bit val;
    val = pe;
    lo = pe ? lo_of(pb) : lo_of(cb);
    hi = pe ? hi_of(pt) : hi_of(ct);
    n  = (hi > lo) ? hi - lo : 0;
    paint_req = pe; paint_base = AW'(pb); paint_top = AW'(pt);
    clear_req = ce; clear_base = AW'(cb); clear_top = AW'(ct);
    @(posedge clk); @(negedge clk);
    paint_req = 0; clear_req = 0;
    chk(range_busy == 1'b1, "R3 busy after request", range_busy, 1);
    cnt = 0;
    while (!range_done && cnt < 1000) begin
      @(posedge clk); @(negedge clk); cnt++;
    end
    chk(cnt == n + 1, "R3 R10 done timing", cnt, n + 1);
    chk(range_busy == 1'b0, "R3 idle at done", range_busy, 0);
    for (int g = lo; g < hi; g++) model[g] = val;
  endtask

  initial begin
    int cnt;
    bit saw_done;
    for (int g = 0; g < NG; g++) model[g] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state and clearing walk
    chk(out_valid == 1'b0, "R1 out_valid reset", out_valid, 0);
    chk(range_busy == 1'b1, "R1 busy during init", range_busy, 1);
    cnt = 0; saw_done = 0;
    while (range_busy && cnt < 1000) begin
      @(posedge clk); @(negedge clk); cnt++;
      if (range_done) saw_done = 1;
    end
    chk(cnt == NG + 1, "R1 init length", cnt, NG + 1);
    chk(!saw_done, "R1 no done for init", saw_done, 0);
    sweep(1'b1);

    // R2: aligned paint, granules 2..4
    range_op(1, 16'h0410, 16'h0428, 0, 0, 0);
    sweep(1'b1);
    // R2: misaligned paint, granules 6..8
    range_op(1, 16'h0433, 16'h0441, 0, 0, 0);
    // R8: straddles both window edges
    range_op(1, 16'h03F0, 16'h0409, 0, 0, 0);
    range_op(1, 16'h05F9, 16'h0700, 0, 0, 0);
    sweep(1'b1);
    sweep(1'b0);
    // R4: clear granule 3
    range_op(0, 0, 0, 1, 16'h0418, 16'h0420);
    // R10: empty ranges
    range_op(1, 16'h0480, 16'h0480, 0, 0, 0);
    range_op(1, 16'h0490, 16'h0480, 0, 0, 0);
    range_op(1, 16'h0700, 16'h0800, 0, 0, 0);
    sweep(1'b1);

    // R5: requests during busy are ignored
    paint_req = 1; paint_base = 16'h0500; paint_top = 16'h0540;
    @(posedge clk); @(negedge clk);
    paint_req = 1; paint_base = 16'h0400; paint_top = 16'h0600;
    clear_req = 1; clear_base = 16'h0400; clear_top = 16'h0600;
    @(posedge clk); @(negedge clk);
    paint_req = 0; clear_req = 0;
    cnt = 1;
    while (!range_done && cnt < 1000) begin
      @(posedge clk); @(negedge clk); cnt++;
    end
    chk(cnt == 9, "R5 busy request ignored", cnt, 9);
    for (int g = 32; g < 40; g++) model[g] = 1;
    sweep(1'b1);
    // R5: simultaneous paint and clear while idle, paint wins
    range_op(1, 16'h05C0, 16'h05C8, 1, 16'h0400, 16'h0600);
    sweep(1'b1);

    // R9: loads in step with paint writes to granules 40..43
    paint_req = 1; paint_base = 16'h0540; paint_top = 16'h0560;
    @(posedge clk); @(negedge clk);
    paint_req = 0;
    for (int k = 0; k < 4; k++) begin
      ld_valid = 1; ld_tag = 1; ld_addr = AW'(16'h0540 + k*GB);
      @(posedge clk); @(negedge clk);
      chk(out_tag == 1'b0, "R9 paint forwarding", out_tag, 0);
    end
    ld_valid = 0;
    while (!range_done) begin @(posedge clk); @(negedge clk); end
    for (int g = 40; g < 44; g++) model[g] = 1;
    // R9: loads in step with clear writes to granules 40..41
    clear_req = 1; clear_base = 16'h0540; clear_top = 16'h0550;
    @(posedge clk); @(negedge clk);
    clear_req = 0;
    for (int k = 0; k < 2; k++) begin
      ld_valid = 1; ld_tag = 1; ld_addr = AW'(16'h0540 + k*GB);
      @(posedge clk); @(negedge clk);
      chk(out_tag == 1'b1, "R9 clear forwarding", out_tag, 1);
    end
    ld_valid = 0;
    while (!range_done) begin @(posedge clk); @(negedge clk); end
    model[40] = 0; model[41] = 0;
    sweep(1'b1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule